// File: doc/BRIEF.md
# Audio Control Command Decoder

This block sits between a command byte source and the analog control of a stereo audio processor. Each byte arrives with a one-cycle valid strobe and carries its own function prefix in its upper bits. The block decodes that prefix and updates only the control fields that the command addresses. Those fields are the attenuation of each channel, the per-channel mute, the soft-mute mode, the loudness setting, the input selection and the channel target for later volume writes. Every field is a register, and a byte presented on one clock edge shows on the outputs after that edge.

A volume byte holds a coarse field in 8 dB steps and a fine field in 1 dB steps. The block converts the two fields into one attenuation value in dB. A coarse code in the top range means full mute. A separate channel-select command decides whether volume writes go to the left channel, the right channel or both. One reserved byte value restores the power-on state. The analog ramp of the soft mute is not part of this block. The block only records which ramp speed is selected.

Top module: `audctl_top`

## Requirements
- R1: A valid byte with bit 7 = 0 is a volume command. Its bits 6:3 are the coarse code C and bits 2:0 the fine code F. For C from 0 to 11 the written channel shows attenuation 8*C + F on its 7-bit attenuation output with its mute flag 0, from the clock edge that takes the byte.
- R2: A volume byte whose coarse code is 12 to 15 (bits 6:5 = 11) sets the written channel's mute flag to 1 and its attenuation output to 127.
- R3: An unmuted channel never shows more than 95 dB: byte 0x5F gives 95 and byte 0x00 gives 0.
- R4: A byte with bits 7:5 = 100 sets the soft-mute mode from bits 1:0: 00 selects slow (softMode 1), 01 selects fast (softMode 2), and 1x turns soft mute off (softMode 0).
- R5: The same byte with prefix 100 sets loudness from bits 3:2: bit 2 = 1 turns it off (loudMode 0), 00 selects 10 dB (loudMode 1) and 10 selects 20 dB (loudMode 2).
- R6: A byte with bits 7:5 = 101 copies its bits 1:0 to inputSel: 00 = muted input, 01 = input 2, 10 = input 3, 11 = input 1.
- R7: A byte with bits 7:5 = 110 sets chanTarget from bits 1:0: 00 gives right (0), 01 gives left (1), and 10 or 11 give both (2).
- R8: A volume write changes only the channels that chanTarget names at that clock edge. The other channel keeps its attenuation and its mute flag.
- R9: A byte with bits 7:5 = 111 other than 0xFE changes no output. So does any cycle with cmdValid low.
- R10: After reset, and on the edge after byte 0xFE, both attenuations are 127 with both mute flags 1, softMode 0, loudMode 0, inputSel 00 and chanTarget 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | cmdByte is valid in this cycle |
| cmdByte | input | 8 | Command byte |
| attnLeft | output | 7 | Left attenuation in dB (127 when muted) |
| attnRight | output | 7 | Right attenuation in dB (127 when muted) |
| muteLeft | output | 1 | Left channel fully muted |
| muteRight | output | 1 | Right channel fully muted |
| softMode | output | 2 | 0 off, 1 slow, 2 fast |
| loudMode | output | 2 | 0 off, 1 10 dB, 2 20 dB |
| inputSel | output | 2 | Input selection code |
| chanTarget | output | 2 | 0 right, 1 left, 2 both |

## Verification
A channel-select command and a volume write can take effect on neighbouring edges. In that case the volume byte must already be routed by the target written one cycle earlier. The bench provokes this by sending bytes back to back with no idle cycle between a channel select and the next volume byte. Its reference model updates the target first and then routes the volume. The scoreboard compares both channels after each edge, so a write that lands on the channel named by the old target is reported against R8.

// File: rtl/audctl_pkg.sv
package audctl_pkg;

  typedef enum logic [1:0] {
    CH_RIGHT = 2'd0,
    CH_LEFT  = 2'd1,
    CH_BOTH  = 2'd2
  } chan_e;

  typedef enum logic [1:0] {
    SM_OFF  = 2'd0,
    SM_SLOW = 2'd1,
    SM_FAST = 2'd2
  } soft_e;

  typedef enum logic [1:0] {
    LD_OFF  = 2'd0,
    LD_10DB = 2'd1,
    LD_20DB = 2'd2
  } loud_e;

  // strobes from control to datapath, at most one function per byte
  typedef struct packed {
    logic volL;
    logic volR;
    logic misc;
    logic inSel;
    logic chan;
    logic preset;
  } strobe_t;

endpackage

// File: rtl/audctl_decode.sv
module audctl_decode
  import audctl_pkg::*;
#(
  parameter logic [7:0] PRESET_BYTE = 8'hFE
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdByte,
  input  chan_e      chanTgt,
  output strobe_t    stb
);

  always_comb begin
    stb = '0;
    if (cmdValid) begin
      casez (cmdByte[7:5])
        3'b0??: begin
          stb.volL = (chanTgt == CH_LEFT)  || (chanTgt == CH_BOTH);
          stb.volR = (chanTgt == CH_RIGHT) || (chanTgt == CH_BOTH);
        end
        3'b100: stb.misc  = 1'b1;
        3'b101: stb.inSel = 1'b1;
        3'b110: stb.chan  = 1'b1;
        default: stb.preset = (cmdByte == PRESET_BYTE);
      endcase
    end
  end

  AST_ONE_FUNCTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.volL | stb.volR, stb.misc, stb.inSel, stb.chan, stb.preset})); // R9

  AST_VOL_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.volL != stb.volR) |-> (chanTgt != CH_BOTH)); // R8

endmodule

// File: rtl/audctl_atten.sv
module audctl_atten #(
  parameter int COARSE_W    = 4,
  parameter int FINE_W      = 3,
  parameter int COARSE_STEP = 8,
  parameter int MAX_COARSE  = 11,
  parameter int ATTN_W      = 7
) (
  input  logic [COARSE_W+FINE_W-1:0] volCode,
  output logic [ATTN_W-1:0]          attnDb,
  output logic                       isMute
);

  localparam logic [ATTN_W-1:0] FULL = {ATTN_W{1'b1}};

  logic [COARSE_W-1:0] coarse;
  logic [FINE_W-1:0]   fine;

  assign coarse = volCode[COARSE_W+FINE_W-1:FINE_W];
  assign fine   = volCode[FINE_W-1:0];
  assign isMute = (int'(coarse) > MAX_COARSE);

  always_comb begin
    if (isMute) attnDb = FULL;
    else        attnDb = ATTN_W'(coarse) * ATTN_W'(COARSE_STEP) + ATTN_W'(fine);
  end

endmodule

// File: rtl/audctl_state.sv
module audctl_state
  import audctl_pkg::*;
#(
  parameter int COARSE_W    = 4,
  parameter int FINE_W      = 3,
  parameter int COARSE_STEP = 8,
  parameter int MAX_COARSE  = 11,
  parameter int ATTN_W      = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    stb,
  input  logic [COARSE_W+FINE_W-1:0] payload,
  output logic [ATTN_W-1:0]          attnQ [2],
  output logic                       muteQ [2],
  output soft_e                      softQ,
  output loud_e                      loudQ,
  output logic [1:0]                 inQ,
  output chan_e                      chanQ
);

  localparam logic [ATTN_W-1:0] FULL   = {ATTN_W{1'b1}};
  localparam int                MAX_DB = MAX_COARSE * COARSE_STEP + (2**FINE_W - 1);

  logic [ATTN_W-1:0] cnvAttn;
  logic              cnvMute;
  logic              wrVol [2];

  assign wrVol[0] = stb.volR;
  assign wrVol[1] = stb.volL;

  audctl_atten #(
    .COARSE_W(COARSE_W), .FINE_W(FINE_W), .COARSE_STEP(COARSE_STEP),
    .MAX_COARSE(MAX_COARSE), .ATTN_W(ATTN_W)
  ) atten_i (
    .volCode(payload),
    .attnDb (cnvAttn),
    .isMute (cnvMute)
  );

  // index 0 = right, 1 = left
  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        attnQ[ch] <= FULL;
        muteQ[ch] <= 1'b1;
      end else if (stb.preset) begin
        attnQ[ch] <= FULL;
        muteQ[ch] <= 1'b1;
      end else if (wrVol[ch]) begin
        attnQ[ch] <= cnvAttn;
        muteQ[ch] <= cnvMute;
      end
    end

    AST_MUTE_FULL: assert property (@(posedge clk) disable iff (!rstN)
      muteQ[ch] |-> (attnQ[ch] == FULL)); // R2

    AST_ATTN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
      !muteQ[ch] |-> (int'(attnQ[ch]) <= MAX_DB)); // R3
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softQ <= SM_OFF;
      loudQ <= LD_OFF;
      inQ   <= 2'b00;
      chanQ <= CH_BOTH;
    end else if (stb.preset) begin
      softQ <= SM_OFF;
      loudQ <= LD_OFF;
      inQ   <= 2'b00;
      chanQ <= CH_BOTH;
    end else begin
      if (stb.misc) begin
        softQ <= payload[1] ? SM_OFF : (payload[0] ? SM_FAST : SM_SLOW);
        loudQ <= payload[2] ? LD_OFF : (payload[3] ? LD_20DB : LD_10DB);
      end
      if (stb.inSel) inQ <= payload[1:0];
      if (stb.chan)  chanQ <= payload[1] ? CH_BOTH : (payload[0] ? CH_LEFT : CH_RIGHT);
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stb == '0) |=> $stable({attnQ[0], attnQ[1], muteQ[0], muteQ[1], softQ, loudQ, inQ, chanQ})); // R9

  AST_PRESET_STATE: assert property (@(posedge clk) disable iff (!rstN)
    stb.preset |=> (chanQ == CH_BOTH && inQ == 2'b00 && softQ == SM_OFF && loudQ == LD_OFF)); // R10

  AST_CHAN_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    chanQ != 2'd3); // R7

endmodule

// File: rtl/audctl_top.sv
module audctl_top
  import audctl_pkg::*;
#(
  parameter int         COARSE_W    = 4,
  parameter int         FINE_W      = 3,
  parameter int         COARSE_STEP = 8,
  parameter int         MAX_COARSE  = 11,
  parameter int         ATTN_W      = 7,
  parameter logic [7:0] PRESET_BYTE = 8'hFE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [7:0]        cmdByte,
  output logic [ATTN_W-1:0] attnLeft,
  output logic [ATTN_W-1:0] attnRight,
  output logic              muteLeft,
  output logic              muteRight,
  output logic [1:0]        softMode,
  output logic [1:0]        loudMode,
  output logic [1:0]        inputSel,
  output logic [1:0]        chanTarget
);

  localparam int VOL_W = COARSE_W + FINE_W;

  strobe_t           stb;
  chan_e             chanQ;
  soft_e             softQ;
  loud_e             loudQ;
  logic [ATTN_W-1:0] attnQ [2];
  logic              muteQ [2];

  audctl_decode #(.PRESET_BYTE(PRESET_BYTE)) decode_i (
    .clk     (clk),
    .rstN    (rstN),
    .cmdValid(cmdValid),
    .cmdByte (cmdByte),
    .chanTgt (chanQ),
    .stb     (stb)
  );

  audctl_state #(
    .COARSE_W(COARSE_W), .FINE_W(FINE_W), .COARSE_STEP(COARSE_STEP),
    .MAX_COARSE(MAX_COARSE), .ATTN_W(ATTN_W)
  ) state_i (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .payload(cmdByte[VOL_W-1:0]),
    .attnQ  (attnQ),
    .muteQ  (muteQ),
    .softQ  (softQ),
    .loudQ  (loudQ),
    .inQ    (inputSel),
    .chanQ  (chanQ)
  );

  assign attnRight  = attnQ[0];
  assign attnLeft   = attnQ[1];
  assign muteRight  = muteQ[0];
  assign muteLeft   = muteQ[1];
  assign softMode   = softQ;
  assign loudMode   = loudQ;
  assign chanTarget = chanQ;

endmodule

// File: tb/audctl_top_tb_top.sv
module audctl_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [7:0] cmdByte = 8'h00;
  logic [6:0] attnLeft, attnRight;
  logic       muteLeft, muteRight;
  logic [1:0] softMode, loudMode, inputSel, chanTarget;

  int nCompared = 0;
  int nMismatched = 0;
  bit finished = 1'b0;

  // reference model
  logic [6:0] mAttnL = 7'd127, mAttnR = 7'd127;
  logic       mMuteL = 1'b1, mMuteR = 1'b1;
  logic [1:0] mSoft = 2'd0, mLoud = 2'd0, mIn = 2'd0, mChan = 2'd2;

  logic [23:0] expQ [$];
  string       tagQ [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  audctl_top dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .attnLeft(attnLeft), .attnRight(attnRight), .muteLeft(muteLeft),
    .muteRight(muteRight), .softMode(softMode), .loudMode(loudMode),
    .inputSel(inputSel), .chanTarget(chanTarget)
  );

  function automatic logic [23:0] modelPack();
    return {mAttnL, mAttnR, mMuteL, mMuteR, mSoft, mLoud, mIn, mChan};
  endfunction

  function automatic void modelApply(logic [7:0] b);
    int coarse;
    logic [6:0] a;
    logic m;
    if (b[7] == 1'b0) begin
      coarse = int'(b[6:3]);
      m = (coarse >= 12);
      a = m ? 7'd127 : 7'(coarse * 8 + int'(b[2:0]));
      if (mChan == 2'd1 || mChan == 2'd2) begin mAttnL = a; mMuteL = m; end
      if (mChan == 2'd0 || mChan == 2'd2) begin mAttnR = a; mMuteR = m; end
    end else if (b[6:5] == 2'b00) begin
      if (b[1]) mSoft = 2'd0; else if (b[0]) mSoft = 2'd2; else mSoft = 2'd1;
      if (b[2]) mLoud = 2'd0; else if (b[3]) mLoud = 2'd2; else mLoud = 2'd1;
    end else if (b[6:5] == 2'b01) begin
      mIn = b[1:0];
    end else if (b[6:5] == 2'b10) begin
      mChan = b[1] ? 2'd2 : {1'b0, b[0]};
    end else if (b == 8'hFE) begin
      mAttnL = 7'd127; mAttnR = 7'd127; mMuteL = 1'b1; mMuteR = 1'b1;
      mSoft = 2'd0; mLoud = 2'd0; mIn = 2'd0; mChan = 2'd2;
    end
  endfunction

  // driver: one byte per cycle, expected result queued for the next edge
  task automatic sendByte(input logic [7:0] b, input string tag);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdByte  = b;
    modelApply(b);
    expQ.push_back(modelPack());
    tagQ.push_back(tag);
  endtask

  task automatic idleCycle(input string tag);
    @(negedge clk);
    cmdValid = 1'b0;
    cmdByte  = 8'hA5;
    expQ.push_back(modelPack());
    tagQ.push_back(tag);
  endtask

  // monitor: compares just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN && expQ.size() > 0) begin
        logic [23:0] exp, act;
        string tag;
        exp = expQ.pop_front();
        tag = tagQ.pop_front();
        act = {attnLeft, attnRight, muteLeft, muteRight, softMode, loudMode, inputSel, chanTarget};
        nCompared++;
        if (act !== exp) begin
          nMismatched++;
          $display("FAIL %s: actual L=%0d R=%0d mL=%b mR=%b soft=%0d loud=%0d in=%0d ch=%0d expected L=%0d R=%0d mL=%b mR=%b soft=%0d loud=%0d in=%0d ch=%0d",
                   tag, act[23:17], act[16:10], act[9], act[8], act[7:6], act[5:4], act[3:2], act[1:0],
                   exp[23:17], exp[16:10], exp[9], exp[8], exp[7:6], exp[5:4], exp[3:2], exp[1:0]);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nMismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idleCycle("R10 reset state");
    sendByte(8'h00, "R1 R8 zero to both");
    sendByte(8'h5F, "R3 max 95 both");
    sendByte(8'h2A, "R1 coarse5 fine2");
    sendByte(8'hC1, "R7 target left");
    sendByte(8'h13, "R8 left only 19");
    sendByte(8'hC0, "R7 target right");
    sendByte(8'h60, "R2 R8 right mute");
    sendByte(8'h47, "R1 R8 right 71");
    sendByte(8'h7F, "R2 mute 1111");
    sendByte(8'hC2, "R7 target both 10");
    sendByte(8'h08, "R1 R8 both 8");
    sendByte(8'hC3, "R7 target both 11");
    sendByte(8'h80, "R4 R5 slow 10dB");
    sendByte(8'h81, "R4 fast");
    sendByte(8'h8A, "R4 R5 off 20dB");
    sendByte(8'h86, "R4 R5 off off");
    sendByte(8'h98, "R4 R5 slow 20dB bit4 set");
    sendByte(8'hA1, "R6 input2");
    sendByte(8'hA2, "R6 input3");
    sendByte(8'hB3, "R6 input1");
    sendByte(8'hA0, "R6 input muted");
    sendByte(8'hE0, "R9 ignored E0");
    sendByte(8'hFF, "R9 ignored FF");
    sendByte(8'hF7, "R9 ignored F7");
    idleCycle("R9 valid low");
    sendByte(8'h58, "R1 coarse11 88");
    sendByte(8'hFE, "R10 preset byte");
    idleCycle("R10 after preset");
    sendByte(8'hC1, "R7 left again");
    sendByte(8'h37, "R8 left 55 right held");
    idleCycle("R9 idle end");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

endmodule